// File: doc/BRIEF.md
# PLL Clock Rate Calculator

This block works out, in hertz, three clock rates that software and neighbouring logic need to know: the reference input rate, the high-speed PLL output rate and the peripheral bus rate. It takes the current PLL parameter word, the clock-select word, the strap word and a variant select. A start strobe samples these plain register values. A shared sequential divider then walks through the required divisions, and the block raises a done flag once all three results are valid.

Two PLL field layouts are supported. Variant 0 is the older layout. Its PLL either follows a fixed frequency table selected by straps or is programmed with n/od/d fields. Variant 1 is the newer layout, with p/m/n fields. Every division truncates and the divisions run in a fixed order, so the results are bit-exact to integer arithmetic. The block computes once by itself after reset is released. A system integrator pulses the start input whenever the clock-select or PLL word is written. The block only computes rates and generates no clocks.

Top module: `pll_rate_calc`

## Requirements
- R1: The reference rate is 25000000 when strap bit 23 is set. Otherwise it is 48000000 when strap bit 18 is set, and 24000000 when neither bit is set.
- R2: When PLL word bit 24 (off) is set, the PLL rate and the bus rate are 0 in both variants, whatever the other bits hold.
- R3: In variant 0 (variant_i = 0), when PLL word bit 10 (programmed) is clear, the PLL rate comes from a table. The index is strap bits 9:8. The values are {384,360,336,408} MHz, or {400,375,350,425} MHz when strap bit 23 is set. The bypass bit has no effect in this case.
- R4: In variant 0, when bit 10 is set and PLL word bit 20 (bypass) is set, the PLL rate equals the reference rate.
- R5: In variant 0, when the PLL is programmed and not bypassed, n = bits 10:5, od = bit 4 and d = bits 3:0. The PLL rate is ref × ((2 − od) × floor((n+2)/(d+1))), truncated to 32 bits.
- R6: In variant 1, bit 10 is ignored. Bypass (bit 20) gives the reference rate. Otherwise p = bits 18:13, m = bits 12:5 and n = bits 4:0, and the PLL rate is ref × floor(floor((m+1)/(n+1))/(p+1)).
- R7: The bus rate is floor(floor(pll / (clk_sel bits 25:23 + 1)) / k), where k = 2 in variant 0 and k = 4 in variant 1.
- R8: done_o and all rates are 0 while reset is held. After reset is released, one computation runs without any start pulse, using the input values present at that moment.
- R9: A start pulse clears done_o on the next cycle. The three rate outputs keep their previous values until done_o rises again with the new results.
- R10: A start pulse during a computation abandons that computation and restarts from the newly sampled inputs. Only one rise of done_o follows, and it carries the restarted result.
- R11: Inputs are sampled in the start cycle. Changes to them during the computation do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sample inputs and (re)start the computation |
| variant_i | input | 1 | 0 = older field layout, 1 = newer field layout |
| pll_reg_i | input | 32 | PLL parameter word |
| clk_sel_i | input | 32 | Clock-select word (bus divider field) |
| strap_i | input | 32 | Strap word (reference select, table index) |
| ref_hz_o | output | 32 | Reference input rate in Hz |
| pll_hz_o | output | 32 | PLL output rate in Hz |
| bus_hz_o | output | 32 | Peripheral bus rate in Hz |
| done_o | output | 1 | All three rates valid |

## Verification
The hardest case to reach is a restart that lands while the divider is partway through a quotient. The stimulus pulses start again a few cycles into a multi-division run. The scoreboard then expects exactly one result, the one for the second set of inputs. Truncation order is exposed by field values whose nested quotients differ from a single combined division, such as n = 33 and d = 1 with od = 0. A large multiplier checks the 32-bit wrap of the product, and a newer-variant setting whose second quotient rounds to zero checks that case.

// File: rtl/pll_rate_pkg.sv
package pll_rate_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLAN,
    ST_Q1,
    ST_Q2,
    ST_BUS
  } calc_st_e;

  localparam logic [31:0] HZ_24M = 32'd24_000_000;
  localparam logic [31:0] HZ_25M = 32'd25_000_000;
  localparam logic [31:0] HZ_48M = 32'd48_000_000;
endpackage

// File: rtl/pll_rate_div.sv
module pll_rate_div #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         valid_o,
  output logic [W-1:0] quot_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, rem_n, quo_q, quo_n, dvs_q, dvs_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n, valid_q, valid_n;
  logic [W:0]    shf, dif;
  logic          ge;

  always_comb begin
    shf = {rem_q, quo_q[W-1]};
    dif = shf - {1'b0, dvs_q};
    ge  = (shf >= {1'b0, dvs_q});
    rem_n = rem_q; quo_n = quo_q; dvs_n = dvs_q;
    cnt_n = cnt_q; busy_n = busy_q; valid_n = 1'b0;
    if (start_i) begin
      rem_n  = '0;
      quo_n  = dividend_i;
      dvs_n  = (divisor_i == '0) ? W'(1) : divisor_i;
      cnt_n  = CW'(W);
      busy_n = 1'b1;
    end else if (busy_q) begin
      rem_n = ge ? dif[W-1:0] : shf[W-1:0];
      quo_n = {quo_q[W-2:0], ge};
      cnt_n = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy_n  = 1'b0;
        valid_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0; quo_q <= '0; dvs_q <= W'(1);
      cnt_q <= '0; busy_q <= 1'b0; valid_q <= 1'b0;
    end else begin
      rem_q <= rem_n; quo_q <= quo_n; dvs_q <= dvs_n;
      cnt_q <= cnt_n; busy_q <= busy_n; valid_q <= valid_n;
    end
  end

  assign valid_o = valid_q;
  assign quot_o  = quo_q;

  // R7: a finished quotient leaves a remainder below the divisor
  p_rem_below_divisor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (rem_q < dvs_q));
  p_valid_is_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
endmodule

// File: rtl/pll_rate_decode.sv
module pll_rate_decode
  import pll_rate_pkg::*;
#(
  parameter int unsigned OFF_BIT  = 24,
  parameter int unsigned BYP_BIT  = 20,
  parameter int unsigned PROG_BIT = 10,
  parameter int unsigned S25_BIT  = 23,
  parameter int unsigned S48_BIT  = 18,
  parameter int unsigned HSEL_LSB = 8
) (
  input  logic [31:0] pll_reg_i,
  input  logic [31:0] strap_i,
  output logic [31:0] ref_hz_o,
  output logic [31:0] table_hz_o,
  output logic        off_o,
  output logic        byp_o,
  output logic        prog_o,
  output logic [5:0]  old_n_o,
  output logic        old_od_o,
  output logic [3:0]  old_d_o,
  output logic [5:0]  new_p_o,
  output logic [7:0]  new_m_o,
  output logic [4:0]  new_n_o
);
  logic       row25;
  logic [1:0] hsel;
  logic       unused_bits;

  assign unused_bits = ^{pll_reg_i, strap_i};

  always_comb begin
    row25 = strap_i[S25_BIT];
    hsel  = strap_i[HSEL_LSB +: 2];
    if (row25)                 ref_hz_o = HZ_25M;
    else if (strap_i[S48_BIT]) ref_hz_o = HZ_48M;
    else                       ref_hz_o = HZ_24M;
    case ({row25, hsel})
      3'b000:  table_hz_o = 32'd384_000_000;
      3'b001:  table_hz_o = 32'd360_000_000;
      3'b010:  table_hz_o = 32'd336_000_000;
      3'b011:  table_hz_o = 32'd408_000_000;
      3'b100:  table_hz_o = 32'd400_000_000;
      3'b101:  table_hz_o = 32'd375_000_000;
      3'b110:  table_hz_o = 32'd350_000_000;
      default: table_hz_o = 32'd425_000_000;
    endcase
  end

  assign off_o    = pll_reg_i[OFF_BIT];
  assign byp_o    = pll_reg_i[BYP_BIT];
  assign prog_o   = pll_reg_i[PROG_BIT];
  assign old_n_o  = pll_reg_i[10:5];
  assign old_od_o = pll_reg_i[4];
  assign old_d_o  = pll_reg_i[3:0];
  assign new_p_o  = pll_reg_i[18:13];
  assign new_m_o  = pll_reg_i[12:5];
  assign new_n_o  = pll_reg_i[4:0];
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
  import pll_rate_pkg::*;
#(
  parameter int unsigned RATE_W   = 32,
  parameter int unsigned OFF_BIT  = 24,
  parameter int unsigned BYP_BIT  = 20,
  parameter int unsigned PROG_BIT = 10,
  parameter int unsigned S25_BIT  = 23,
  parameter int unsigned S48_BIT  = 18,
  parameter int unsigned HSEL_LSB = 8,
  parameter int unsigned DIV_LSB  = 23,
  parameter int unsigned DIV_W    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        variant_i,
  input  logic [31:0] pll_reg_i,
  input  logic [31:0] clk_sel_i,
  input  logic [31:0] strap_i,
  output logic [31:0] ref_hz_o,
  output logic [31:0] pll_hz_o,
  output logic [31:0] bus_hz_o,
  output logic        done_o
);
  calc_st_e          st_q, st_n;
  logic              boot_q, boot_n, var_q, var_n, done_q, done_n;
  logic [31:0]       pllr_q, pllr_n, selr_q, selr_n, strap_q, strap_n;
  logic [RATE_W-1:0] refw_q, refw_n, pllw_q, pllw_n;
  logic [RATE_W-1:0] ref_o_q, ref_o_n, pll_o_q, pll_o_n, bus_o_q, bus_o_n;

  logic [31:0] dec_ref, dec_tab;
  logic        dec_off, dec_byp, dec_prog, dec_od;
  logic [5:0]  dec_on, dec_p;
  logic [3:0]  dec_d;
  logic [7:0]  dec_m;
  logic [4:0]  dec_nn;

  logic              div_start, div_valid;
  logic [RATE_W-1:0] div_dd, div_ds, div_q;
  logic              bus_go;
  logic [RATE_W-1:0] pll_val;
  logic              unused_sel;

  assign unused_sel = ^selr_q;

  pll_rate_decode #(
    .OFF_BIT(OFF_BIT), .BYP_BIT(BYP_BIT), .PROG_BIT(PROG_BIT),
    .S25_BIT(S25_BIT), .S48_BIT(S48_BIT), .HSEL_LSB(HSEL_LSB)
  ) u_dec (
    .pll_reg_i(pllr_q), .strap_i(strap_q),
    .ref_hz_o(dec_ref), .table_hz_o(dec_tab),
    .off_o(dec_off), .byp_o(dec_byp), .prog_o(dec_prog),
    .old_n_o(dec_on), .old_od_o(dec_od), .old_d_o(dec_d),
    .new_p_o(dec_p), .new_m_o(dec_m), .new_n_o(dec_nn)
  );

  pll_rate_div #(.W(RATE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start_i(div_start),
    .dividend_i(div_dd), .divisor_i(div_ds),
    .valid_o(div_valid), .quot_o(div_q)
  );

  always_comb begin
    st_n = st_q; boot_n = boot_q; var_n = var_q; done_n = done_q;
    pllr_n = pllr_q; selr_n = selr_q; strap_n = strap_q;
    refw_n = refw_q; pllw_n = pllw_q;
    ref_o_n = ref_o_q; pll_o_n = pll_o_q; bus_o_n = bus_o_q;
    div_start = 1'b0; div_dd = '0; div_ds = RATE_W'(1);
    bus_go = 1'b0; pll_val = '0;
    if (start_i || boot_q) begin
      boot_n = 1'b0; done_n = 1'b0; st_n = ST_PLAN;
      var_n = variant_i; pllr_n = pll_reg_i;
      selr_n = clk_sel_i; strap_n = strap_i;
    end else begin
      case (st_q)
        ST_PLAN: begin
          refw_n = RATE_W'(dec_ref);
          if (dec_off) begin
            bus_go = 1'b1; pll_val = '0;
          end else if (!var_q && !dec_prog) begin
            bus_go = 1'b1; pll_val = RATE_W'(dec_tab);
          end else if (dec_byp) begin
            bus_go = 1'b1; pll_val = RATE_W'(dec_ref);
          end else begin
            div_start = 1'b1; st_n = ST_Q1;
            if (!var_q) begin
              div_dd = RATE_W'(dec_on) + RATE_W'(2);
              div_ds = RATE_W'(dec_d) + RATE_W'(1);
            end else begin
              div_dd = RATE_W'(dec_m) + RATE_W'(1);
              div_ds = RATE_W'(dec_nn) + RATE_W'(1);
            end
          end
        end
        ST_Q1: if (div_valid) begin
          if (!var_q) begin
            bus_go  = 1'b1;
            pll_val = refw_q * (dec_od ? div_q : {div_q[RATE_W-2:0], 1'b0});
          end else begin
            div_start = 1'b1; st_n = ST_Q2;
            div_dd = div_q;
            div_ds = RATE_W'(dec_p) + RATE_W'(1);
          end
        end
        ST_Q2: if (div_valid) begin
          bus_go = 1'b1; pll_val = refw_q * div_q;
        end
        ST_BUS: if (div_valid) begin
          bus_o_n = var_q ? (div_q >> 2) : (div_q >> 1);
          ref_o_n = refw_q; pll_o_n = pllw_q;
          done_n = 1'b1; st_n = ST_IDLE;
        end
        default: ;
      endcase
      if (bus_go) begin
        pllw_n = pll_val; div_start = 1'b1; st_n = ST_BUS;
        div_dd = pll_val;
        div_ds = RATE_W'(selr_q[DIV_LSB +: DIV_W]) + RATE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; boot_q <= 1'b1; var_q <= 1'b0; done_q <= 1'b0;
      pllr_q <= '0; selr_q <= '0; strap_q <= '0;
      refw_q <= '0; pllw_q <= '0;
      ref_o_q <= '0; pll_o_q <= '0; bus_o_q <= '0;
    end else begin
      st_q <= st_n; boot_q <= boot_n; var_q <= var_n; done_q <= done_n;
      pllr_q <= pllr_n; selr_q <= selr_n; strap_q <= strap_n;
      refw_q <= refw_n; pllw_q <= pllw_n;
      ref_o_q <= ref_o_n; pll_o_q <= pll_o_n; bus_o_q <= bus_o_n;
    end
  end

  assign ref_hz_o = 32'(ref_o_q);
  assign pll_hz_o = 32'(pll_o_q);
  assign bus_hz_o = 32'(bus_o_q);
  assign done_o   = done_q;

  p_start_clears_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_q);
  p_outputs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done_q) |-> ($stable(ref_o_q) && $stable(pll_o_q) && $stable(bus_o_q)));
  p_off_gives_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && pllr_q[OFF_BIT]) |-> (pll_o_q == '0 && bus_o_q == '0));
  p_bus_not_above_pll_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (bus_o_q <= pll_o_q));
  p_ref_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (ref_o_q == RATE_W'(HZ_24M) || ref_o_q == RATE_W'(HZ_25M) ||
                ref_o_q == RATE_W'(HZ_48M)));
  p_done_only_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st_q == ST_IDLE));
endmodule

// File: tb/pll_rate_calc_tb_top.sv
module pll_rate_calc_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        variant = 1'b0;
  logic [31:0] pll_reg = '0, clk_sel = '0, strap = '0;
  logic [31:0] ref_hz, pll_hz, bus_hz;
  logic        done;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] r;
    logic [31:0] p;
    logic [31:0] b;
    string       req;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_rate_calc dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .variant_i(variant),
    .pll_reg_i(pll_reg), .clk_sel_i(clk_sel), .strap_i(strap),
    .ref_hz_o(ref_hz), .pll_hz_o(pll_hz), .bus_hz_o(bus_hz), .done_o(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tab_hz(input logic r25, input logic [1:0] s);
    logic [31:0] mhz;
    case (s)
      2'd0: mhz = r25 ? 400 : 384;
      2'd1: mhz = r25 ? 375 : 360;
      2'd2: mhz = r25 ? 350 : 336;
      default: mhz = r25 ? 425 : 408;
    endcase
    return mhz * 32'd1_000_000;
  endfunction

  function automatic exp_t model(input logic v, input logic [31:0] pr,
                                 input logic [31:0] cs, input logic [31:0] st,
                                 input string req);
    exp_t e;
    logic [31:0] mult;
    e.req = req;
    e.r = st[23] ? 32'd25_000_000 : (st[18] ? 32'd48_000_000 : 32'd24_000_000);
    if (pr[24]) e.p = 0;
    else if (!v && !pr[10]) e.p = tab_hz(st[23], st[9:8]);
    else if (pr[20]) e.p = e.r;
    else begin
      if (!v) mult = (32'd2 - 32'(pr[4])) * ((32'(pr[10:5]) + 2) / (32'(pr[3:0]) + 1));
      else    mult = ((32'(pr[12:5]) + 1) / (32'(pr[4:0]) + 1)) / (32'(pr[18:13]) + 1);
      e.p = e.r * mult;
    end
    e.b = (e.p / (32'(cs[25:23]) + 1)) / (v ? 32'd4 : 32'd2);
    return e;
  endfunction

  task automatic kick(input logic v, input logic [31:0] pr, input logic [31:0] cs,
                      input logic [31:0] st, input bit push, input string req);
    @(negedge clk);
    variant = v; pll_reg = pr; clk_sel = cs; strap = st; start = 1'b1;
    if (push) sb_q.push_back(model(v, pr, cs, st, req));
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run(input logic v, input logic [31:0] pr, input logic [31:0] cs,
                     input logic [31:0] st, input string req);
    kick(v, pr, cs, st, 1'b1, req);
    wait_done();
  endtask

  // monitor: pop one expected item per rise of done
  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && !done_prev) begin
        if (sb_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10 unexpected result actual=%0d expected=none", pll_hz);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk({e.req, " ref"}, ref_hz, e.r);
          chk({e.req, " pll"}, pll_hz, e.p);
          chk({e.req, " bus"}, bus_hz, e.b);
        end
      end
      done_prev <= done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [31:0] S25 = 32'h1 << 23;
  localparam logic [31:0] S48 = 32'h1 << 18;
  localparam logic [31:0] OFF = 32'h1 << 24;
  localparam logic [31:0] BYP = 32'h1 << 20;
  localparam logic [31:0] PRG = 32'h1 << 10;

  function automatic logic [31:0] seldiv(input int d);
    return 32'(d) << 23;
  endfunction

  initial begin
    sb_q.push_back(model(1'b0, '0, '0, '0, "R8 boot"));
    repeat (3) @(negedge clk);
    chk("R8 reset done", 32'(done), 0);
    chk("R8 reset pll", pll_hz, 0);
    chk("R8 reset bus", bus_hz, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 not yet done", 32'(done), 0);
    wait_done();

    run(1'b0, '0, '0, S25 | (32'd3 << 8), "R3 table 25M idx3");
    run(1'b0, '0, seldiv(1), S48 | (32'd2 << 8), "R1 48M idx2");
    run(1'b0, '0, '0, S25 | S48 | (32'd1 << 8), "R1 both straps");
    run(1'b0, OFF | PRG | BYP, '0, '0, "R2 off old");
    run(1'b0, PRG | BYP, seldiv(5), S48, "R4 bypass");
    run(1'b0, BYP, '0, '0, "R3 bypass without programmed");
    run(1'b0, (32'd33 << 5) | 32'd1, seldiv(7), '0, "R5 truncation");
    run(1'b0, (32'd40 << 5) | (32'd1 << 4) | 32'd3, seldiv(2), '0, "R5 od set");
    run(1'b0, (32'd63 << 5), '0, S48, "R5 wrap");
    run(1'b1, (32'd1 << 13) | (32'd95 << 5) | 32'd1, seldiv(3), '0, "R6 R7 newer");
    run(1'b1, BYP | (32'd7 << 5), seldiv(4), S25, "R6 bypass");
    run(1'b1, OFF | BYP, '0, S48, "R2 off newer");
    run(1'b1, (32'd63 << 13) | (32'd255 << 5) | 32'd31, '0, '0, "R6 zero quotient");

    // R9 hold and R11 input change during computation
    begin
      logic [31:0] ref_a, pll_a, bus_a;
      ref_a = ref_hz; pll_a = pll_hz; bus_a = bus_hz;
      kick(1'b1, (32'd2 << 13) | (32'd47 << 5) | 32'd3, seldiv(1), S48, 1'b1, "R11 sampled inputs");
      chk("R9 done cleared", 32'(done), 0);
      pll_reg = OFF; strap = S25; variant = 1'b0; clk_sel = seldiv(6);
      repeat (5) @(negedge clk);
      chk("R9 hold ref", ref_hz, ref_a);
      chk("R9 hold pll", pll_hz, pll_a);
      chk("R9 hold bus", bus_hz, bus_a);
      wait_done();
    end

    // R10 restart mid-division
    kick(1'b0, (32'd50 << 5) | 32'd2, seldiv(3), '0, 1'b0, "R10 abandoned");
    repeat (6) @(negedge clk);
    kick(1'b1, (32'd1 << 13) | (32'd71 << 5) | 32'd2, seldiv(2), S25, 1'b1, "R10 restarted");
    wait_done();
    repeat (200) @(negedge clk);
    chk("R10 queue drained", 32'(sb_q.size()), 0);
    chk("R10 done held", 32'(done), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule